// File: doc/BRIEF.md
# GPIO Edge Event Mapper

This block watches a vector of 32 already-synchronized GPIO levels and records rising and falling transitions in two status registers, one per polarity. A per-pin enable for each polarity decides whether a transition is recorded. Software clears a recorded event by writing a one to its status bit. Zero bits in that write have no effect.

Each pin owns a 4-bit routing field. The three low bits of the field pick one of eight event-pair outputs. The top bit marks the pin as a power-management source. An event-pair output stays high while any pin routed to it has a recorded event whose polarity is still enabled. The power-management output stays high while any such pin has its flag set.

Registers sit on a simple single-cycle bus with a combinational read. The pins are split into a low bank (pins 0–15) and a high bank (pins 16–31). The high bank's registers sit at the low bank's address plus 0x80. Within a bank, bit n of a per-pin register belongs to pin (16 × bank + n), and only bits 15:0 are used. Word offsets within a bank:

- 0x00: rise enable.
- 0x04: fall enable.
- 0x08: rise status.
- 0x0C: fall status.

The four routing words sit at 0x40, 0x44, 0x48 and 0x4C and cover pins 0–7, 8–15, 16–23 and 24–31 in that order.

Top module: `gpio_evt_mapper`

## Requirements
- R1: After reset, every status bit, enable bit and routing field is zero, and the event-pair and power-management outputs are low.
- R2: A 0→1 change of a pin whose rise enable is set sets that pin's bit in the rise status word. The bit is readable at the first clock edge that samples the new level. Pin p < 16 appears at 0x08 bit p, and pin p ≥ 16 appears at 0x88 bit p−16.
- R3: A 1→0 change of a pin whose fall enable is set sets that pin's bit in the fall status word (0x0C or 0x8C), with the same timing as R2.
- R4: A change of a pin whose enable for that polarity is clear leaves both status words unchanged.
- R5: Writing a status word clears every bit written as 1 at the next clock edge and leaves bits written as 0 unchanged. This holds in both banks.
- R6: If a recorded edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R7: Pin p's routing field is bits 4·(p mod 8)+3 : 4·(p mod 8) of the routing word at 0x40 + 4·(p div 8). Bits 2:0 of the field give the index of the event-pair output. That output is high while the pin has a pending event.
- R8: Routing field bit 3 set makes the power-management output high while the pin has a pending event. The output drops once no flagged pin is pending.
- R9: A pin is pending only while a status bit is set and that polarity's enable is also set. Clearing the enable removes the pin's effect on the outputs, but the status bit remains readable.
- R10: The enable words and routing words read back the last value written (enables in bits 15:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Synchronized pin levels |
| pair_evt | output | 8 | One line per event pair, high while a routed pin is pending |
| pme_evt | output | 1 | High while any pending pin is flagged for power management |

## Verification
The bench drives each polarity on an enabled pin and on a disabled pin. This separates recording from gating in both banks. Routing is tried with three pins on three different pairs, and only one of them carries the power-management flag. That pattern shows the nibble position, the pair index and the flag bit independently. Two clearing patterns are used. A write of ones to unset bits shows that zeros and unrelated bits are left alone. A clearing write placed in the same cycle as a fresh edge shows that the set side wins. An enable is withdrawn and restored while its status bit stays set, which separates pending from recorded.

// File: rtl/gem_pkg.sv
package gem_pkg;
  localparam int FIELD_W = 4;
  // Word indices inside a bank (byte address bits [6:2])
  localparam int W_EN_RISE = 0;
  localparam int W_EN_FALL = 1;
  localparam int W_ST_RISE = 2;
  localparam int W_ST_FALL = 3;
  localparam int W_MAP0    = 16;

  function automatic logic [2:0] pair_sel(input logic [FIELD_W-1:0] fld);
    return fld[2:0];
  endfunction

  function automatic logic pme_flag(input logic [FIELD_W-1:0] fld);
    return fld[3];
  endfunction

  // Next status value: a new edge always wins over a clear
  function automatic logic next_status(input logic cur, input logic clr, input logic hit);
    return (cur & ~clr) | hit;
  endfunction
endpackage

// File: rtl/gem_edge_detect.sv
module gem_edge_detect #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/gem_status_bank.sv
module gem_status_bank
  import gem_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] clr,
  output logic [N-1:0] sts
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts[i] <= 1'b0;
      else        sts[i] <= next_status(sts[i], clr[i], hit[i]);
    end
  end
endmodule

// File: rtl/gem_event_router.sv
module gem_event_router
  import gem_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int NPAIRS = 8
) (
  input  logic [NPINS-1:0]         pend,
  input  logic [NPINS*FIELD_W-1:0] map_flat,
  output logic [NPAIRS-1:0]        pair_evt,
  output logic                     pme_evt
);
  for (genvar g = 0; g < NPAIRS; g++) begin : g_pair
    always_comb begin
      pair_evt[g] = 1'b0;
      for (int p = 0; p < NPINS; p++) begin
        if (pend[p] && int'(pair_sel(map_flat[p*FIELD_W +: FIELD_W])) == g)
          pair_evt[g] = 1'b1;
      end
    end
  end

  always_comb begin
    pme_evt = 1'b0;
    for (int p = 0; p < NPINS; p++) begin
      if (pend[p] && pme_flag(map_flat[p*FIELD_W +: FIELD_W]))
        pme_evt = 1'b1;
    end
  end
endmodule

// File: rtl/gpio_evt_mapper.sv
module gpio_evt_mapper
  import gem_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int NPAIRS = 8,
  parameter int BANK_W = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPAIRS-1:0] pair_evt,
  output logic              pme_evt
);
  localparam int NBANKS       = NPINS / BANK_W;
  localparam int PINS_PER_MAP = DATA_W / FIELD_W;
  localparam int NMAPS        = NPINS / PINS_PER_MAP;
  localparam int WORD_W       = ADDR_W - 3;

  logic              bank;
  logic [WORD_W-1:0] word;
  assign bank = bus_addr[ADDR_W-1];
  assign word = bus_addr[ADDR_W-2:2];

  logic unused_addr;
  assign unused_addr = ^bus_addr[1:0];

  logic [1:0][NPINS-1:0] en_q, edge_v, hit_v, clr_v, sts_v;
  logic [NMAPS-1:0][DATA_W-1:0] map_q;
  logic [NPINS*FIELD_W-1:0]     map_flat;

  // Named internal events for the checker
  logic [NPINS-1:0] hit_rise, hit_fall, clr_rise, clr_fall, sts_rise, sts_fall, pend;

  gem_edge_detect #(.N(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pin_in),
    .rise(edge_v[0]), .fall(edge_v[1])
  );

  // Register writes: enables per bank, routing words in bank 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      map_q <= '0;
    end else if (bus_wr) begin
      for (int pol = 0; pol < 2; pol++)
        for (int b = 0; b < NBANKS; b++)
          if (int'(bank) == b && int'(word) == W_EN_RISE + pol)
            en_q[pol][b*BANK_W +: BANK_W] <= bus_wdata[BANK_W-1:0];
      for (int m = 0; m < NMAPS; m++)
        if (!bank && int'(word) == W_MAP0 + m)
          map_q[m] <= bus_wdata;
    end
  end

  // Write-one-to-clear strobes for the status words
  always_comb begin
    clr_v = '0;
    for (int pol = 0; pol < 2; pol++)
      for (int b = 0; b < NBANKS; b++)
        if (bus_wr && int'(bank) == b && int'(word) == W_ST_RISE + pol)
          clr_v[pol][b*BANK_W +: BANK_W] = bus_wdata[BANK_W-1:0];
  end

  for (genvar pol = 0; pol < 2; pol++) begin : g_pol
    assign hit_v[pol] = edge_v[pol] & en_q[pol];
    gem_status_bank #(.N(NPINS)) u_sts (
      .clk(clk), .rst_n(rst_n), .hit(hit_v[pol]), .clr(clr_v[pol]), .sts(sts_v[pol])
    );
  end

  for (genvar m = 0; m < NMAPS; m++) begin : g_map
    assign map_flat[m*DATA_W +: DATA_W] = map_q[m];
  end

  assign hit_rise = hit_v[0];
  assign hit_fall = hit_v[1];
  assign clr_rise = clr_v[0];
  assign clr_fall = clr_v[1];
  assign sts_rise = sts_v[0];
  assign sts_fall = sts_v[1];
  assign pend     = (sts_v[0] & en_q[0]) | (sts_v[1] & en_q[1]);

  gem_event_router #(.NPINS(NPINS), .NPAIRS(NPAIRS)) u_route (
    .pend(pend), .map_flat(map_flat), .pair_evt(pair_evt), .pme_evt(pme_evt)
  );

  // Combinational read mux
  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (int'(bank) == b) begin
        for (int pol = 0; pol < 2; pol++) begin
          if (int'(word) == W_EN_RISE + pol)
            bus_rdata[BANK_W-1:0] = en_q[pol][b*BANK_W +: BANK_W];
          if (int'(word) == W_ST_RISE + pol)
            bus_rdata[BANK_W-1:0] = sts_v[pol][b*BANK_W +: BANK_W];
        end
      end
    end
    for (int m = 0; m < NMAPS; m++)
      if (!bank && int'(word) == W_MAP0 + m)
        bus_rdata = map_q[m];
  end
endmodule

// File: rtl/gem_checker.sv
module gem_checker #(
  parameter int NPINS  = 32,
  parameter int NPAIRS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPINS-1:0]  hit_rise,
  input logic [NPINS-1:0]  hit_fall,
  input logic [NPINS-1:0]  clr_rise,
  input logic [NPINS-1:0]  clr_fall,
  input logic [NPINS-1:0]  sts_rise,
  input logic [NPINS-1:0]  sts_fall,
  input logic [NPINS-1:0]  pend,
  input logic [NPAIRS-1:0] pair_evt,
  input logic              pme_evt
);
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (sts_rise == '0 && sts_fall == '0));

  a_r2_rise_records: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_rise != '0) |=> ((sts_rise & $past(hit_rise)) == $past(hit_rise)));

  a_r3_fall_records: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_fall != '0) |=> ((sts_fall & $past(hit_fall)) == $past(hit_fall)));

  a_r4_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_rise & ~$past(sts_rise) & ~$past(hit_rise)) == '0));

  a_r4_no_spurious_fall: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_fall & ~$past(sts_fall) & ~$past(hit_fall)) == '0));

  a_r5_clear_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rise != '0) |=> ((sts_rise & $past(clr_rise & ~hit_rise)) == '0));

  a_r5_clear_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fall != '0) |=> ((sts_fall & $past(clr_fall & ~hit_fall)) == '0));

  a_r9_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (pair_evt == '0 && !pme_evt));
endmodule

bind gpio_evt_mapper gem_checker #(.NPINS(NPINS), .NPAIRS(NPAIRS)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .hit_rise(hit_rise), .hit_fall(hit_fall),
  .clr_rise(clr_rise), .clr_fall(clr_fall),
  .sts_rise(sts_rise), .sts_fall(sts_fall),
  .pend(pend), .pair_evt(pair_evt), .pme_evt(pme_evt)
);

// File: tb/gpio_evt_mapper_tb_top.sv
module gpio_evt_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [7:0]  pair_evt;
  logic        pme_evt;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_evt_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pair_evt(pair_evt), .pme_evt(pme_evt)
  );

  typedef struct {
    bit          is_out;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sb_q[$];

  // Monitor: compares pending expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it  = sb_q.pop_front();
        got = it.is_out ? {23'b0, pme_evt, pair_evt} : bus_rdata;
        n_cmp++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pins(input logic [31:0] v);
    pin_in = v;
    @(negedge clk);
  endtask

  task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string r);
    bus_addr = a;
    sb_q.push_back('{1'b0, e, r});
    @(negedge clk);
  endtask

  task automatic exp_out(input logic [8:0] e, input string r);
    sb_q.push_back('{1'b1, {23'b0, e}, r});
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    exp_rd(8'h08, 32'h0, "R1 rise status lo");
    exp_rd(8'h8C, 32'h0, "R1 fall status hi");
    exp_rd(8'h48, 32'h0, "R1 routing word 2");
    exp_out(9'h000, "R1 outputs");
    // Enables: rise on pins 0,5,16; fall on pin 18
    wr(8'h00, 32'h0000_0021);
    wr(8'h80, 32'h0000_0001);
    wr(8'h84, 32'h0000_0004);
    // Routing: pin5 -> pair3; pin16 -> pair1; pin18 -> pair6 + pme
    wr(8'h40, 32'h0030_0000);
    wr(8'h48, 32'h0000_0E01);
    exp_rd(8'h00, 32'h0000_0021, "R10 rise enable lo readback");
    exp_rd(8'h48, 32'h0000_0E01, "R10 routing readback");
    // R2 rising edge on pin5
    pins(32'h0000_0020);
    exp_rd(8'h08, 32'h0000_0020, "R2 rise status pin5");
    exp_out(9'h008, "R7 pin5 drives pair3");
    // R4 rising on unenabled pin1, falling on pin5 with fall disabled
    pins(32'h0000_0022);
    exp_rd(8'h08, 32'h0000_0020, "R4 pin1 rise ignored");
    pins(32'h0000_0002);
    exp_rd(8'h0C, 32'h0, "R4 pin5 fall ignored");
    // Pin18 rise (disabled) then fall (enabled)
    pins(32'h0004_0002);
    exp_rd(8'h8C, 32'h0, "R4 pin18 rise ignored");
    exp_rd(8'h88, 32'h0, "R4 hi rise status untouched");
    pins(32'h0000_0002);
    exp_rd(8'h8C, 32'h0000_0004, "R3 fall status pin18");
    exp_out(9'h148, "R8 pin18 pair6 with pme");
    // R5 clearing
    wr(8'h08, 32'h0000_0001);
    exp_rd(8'h08, 32'h0000_0020, "R5 zero bits unaffected");
    wr(8'h08, 32'h0000_0020);
    exp_rd(8'h08, 32'h0, "R5 clear pin5");
    exp_out(9'h140, "R7 pair3 dropped after clear");
    // R9 enable gating of pending
    wr(8'h84, 32'h0);
    exp_rd(8'h8C, 32'h0000_0004, "R9 status kept while disabled");
    exp_out(9'h000, "R9 outputs drop while disabled");
    wr(8'h84, 32'h0000_0004);
    exp_out(9'h140, "R9 outputs return on re-enable");
    // R6 edge and clear in the same cycle on pin16
    pins(32'h0001_0002);
    exp_rd(8'h88, 32'h0000_0001, "R2 rise status pin16");
    exp_out(9'h142, "R7 pin16 drives pair1");
    pins(32'h0000_0002);
    pin_in = 32'h0001_0002;
    wr(8'h88, 32'h0000_0001);
    exp_rd(8'h88, 32'h0000_0001, "R6 edge beats clear");
    wr(8'h88, 32'h0000_0001);
    exp_rd(8'h88, 32'h0, "R5 clear hi bank");
    // Pin0 rise -> pair0; then clear the pme source
    pins(32'h0001_0003);
    exp_out(9'h141, "R7 pin0 drives pair0");
    wr(8'h8C, 32'h0000_0004);
    exp_out(9'h001, "R8 pme drops after clear");
    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule